// File: doc/BRIEF.md
# TDM Channel Timeslot Mapper

This block places the two bearer channels (B1, B2, 8 bits each) and the signalling channel (D, 2 bits) of a basic-rate line onto a serial TDM frame. A bit-clock tick (`bit_en`, one system-clock pulse per serial bit) and a frame sync sampled on that tick set the bit position. For every bit position the block works out which channel owns the bit. It then drives the serial output with that channel's transmit data, most significant bit first, and shifts the serial input into that channel's receive register.

Positions come from one of three sources. With no channel enable set, fixed default positions are used. Setting any per-channel enable switches all three channels into programmable timeslot mode. In that mode each channel starts at its own configured bit offset, and a channel whose enable is clear is dropped from the frame. For such a channel, the line transmitter is also told to send idle ones. An alternate frame mode lays the three channels out inside one selected 32-bit slot of a larger frame. In that mode a data clock is produced by dividing the system clock, which is the 12.288 MHz reference.

The serial output either drives actively during channel bits and floats elsewhere, or works as open drain, pulling low only for zero bits.

Top module: `tdm_slot_mapper`

## Requirements
- R1: A bit tick with `fsync` high makes the next bit position 0. Each later bit tick advances the position by one, and the position does not move between ticks. After reset the position is the last bit of the frame (FRAME_BITS-1), so `ser_oe`, `rx_valid`, `line_ones` and `dcl_out` are all 0.
- R2: With `cfg_en` = 000 and the alternate mode off, B1 owns bits 0-7, B2 owns bits 8-15 and D owns bits 16-17, and all three are driven.
- R3: With any bit of `cfg_en` set (bit 0 = B1, bit 1 = B2, bit 2 = D), each channel starts at its `cfg_pos_*` offset. A channel whose enable bit is 0 owns no bits, so the output floats in its slot.
- R4: `line_ones[c]` is 1 exactly when `cfg_en` is non-zero and `cfg_en[c]` is 0, with the same bit order as `cfg_en`.
- R5: Bit k of a channel's slot carries transmit bit (length-1-k): `tx_b1[7-k]`, `tx_b2[7-k]`, `tx_d[1-k]`.
- R6: When slots overlap, B1 takes precedence over B2, and B2 takes precedence over D. Only the winner drives and captures.
- R7: With `cfg_open_drain` = 0, `ser_oe` is 1 exactly on owned bits and `ser_out` then equals the data bit. On all other bits `ser_oe` is 0 and `ser_out` is 1.
- R8: With `cfg_open_drain` = 1, `ser_oe` is 1 only on owned bits whose data is 0, and `ser_out` is 0 on those bits. All other bits are released (`ser_oe` = 0, `ser_out` = 1).
- R9: With `cfg_alt_mode` = 1, the channel starts become 32*`cfg_alt_slot` for B1, plus 8 for B2 and plus 24 for D, replacing `cfg_pos_*`. The enables then act as in R3.
- R10: With `cfg_alt_mode` = 1, `dcl_out` has a period of 6 system clocks for codes 00 and 01, 8 for code 10 and 24 for code 11. With the mode off, `dcl_out` is 0.
- R11: A new `cfg_clk_sel` value takes effect only at the next frame-sync bit tick.
- R12: On each bit tick the serial input is shifted into the owning channel's receive register, MSB first. After the tick that ends the channel's last bit, `rx_valid[c]` pulses for one clock and the full value appears on `rx_*`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider reference |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-clock pulse per serial bit |
| fsync | input | 1 | Frame sync, sampled on `bit_en` |
| ser_in | input | 1 | Serial receive data |
| cfg_en | input | 3 | Per-channel timeslot enables (B1, B2, D) |
| cfg_pos_b1 | input | $clog2(FRAME_BITS) | B1 start bit offset |
| cfg_pos_b2 | input | $clog2(FRAME_BITS) | B2 start bit offset |
| cfg_pos_d | input | $clog2(FRAME_BITS) | D start bit offset |
| cfg_open_drain | input | 1 | Output drive style: 1 = open drain |
| cfg_alt_mode | input | 1 | Alternate 32-bit-slot frame mode |
| cfg_alt_slot | input | 3 | Slot used in alternate mode |
| cfg_clk_sel | input | 2 | Data clock rate code |
| tx_b1 | input | 8 | B1 transmit byte |
| tx_b2 | input | 8 | B2 transmit byte |
| tx_d | input | 2 | D transmit bits |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Output enable for the serial pad |
| line_ones | output | 3 | Per-channel idle-ones request toward the line |
| rx_b1 | output | 8 | Last received B1 byte |
| rx_b2 | output | 8 | Last received B2 byte |
| rx_d | output | 2 | Last received D bits |
| rx_valid | output | 3 | One-clock pulse per channel when its receive value is complete |
| dcl_out | output | 1 | Alternate-mode data clock |

## Verification
The mapping is driven through all eight enable combinations, each under both drive styles. This separates the default layout from the programmed layout, shows that a cleared enable removes exactly its own channel, and shows that the open-drain style floats the one bits that push-pull drives. Two alternate-mode frames show that the slot base replaces the programmed offsets while the enables still apply. An overlapping layout shows the precedence order. A serial input pattern that differs from the transmit data shows that each receive register collects only the bits its channel owns. The clock codes are measured before and after a frame sync, which shows that a code change waits for the frame boundary.

// File: rtl/tsm_pkg.sv
// Shared constants and helpers for the TDM channel timeslot mapper.
// Channel index 0 = B1, 1 = B2, 2 = D; lower index wins on overlap.
package tsm_pkg;
    localparam int NUM_CH        = 3;
    localparam int B_BITS        = 8;
    localparam int D_BITS        = 2;
    localparam int IDX_W         = $clog2(B_BITS);
    localparam int DEF_SPAN      = 8;
    localparam int GCI_SLOT_BITS = 32;
    localparam int GCI_B2_OFS    = 8;
    localparam int GCI_D_OFS     = 24;

    // Number of bits the channel occupies per frame.
    function automatic int ch_len(input int c);
        return (c == 2) ? D_BITS : B_BITS;
    endfunction

    // Offset of the channel inside an alternate-mode slot.
    function automatic int gci_ofs(input int c);
        return (c == 0) ? 0 : ((c == 1) ? GCI_B2_OFS : GCI_D_OFS);
    endfunction

    // Fixed start position used when no enable is set.
    function automatic int def_ofs(input int c);
        return c * DEF_SPAN;
    endfunction
endpackage

// File: rtl/tsm_bit_counter.sv
// Bit position counter for the serial frame.
// Assumes bit_en is a one-clock pulse per serial bit; fsync is only
// looked at on that pulse. Reset parks on the last frame bit.
module tsm_bit_counter #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             fsync,
    output logic [POS_W-1:0] cnt
);
    // Advance once per bit, restart after a sync bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '1;
        else if (bit_en) cnt <= fsync ? '0 : cnt + 1'b1;
    end

    // R1
    // hold_between_ticks_chk
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cnt));
endmodule

// File: rtl/tsm_slot_decode.sv
// Decides which channel owns the current bit and where inside the
// channel that bit lies. Purely combinational; assumes POS_W >= 8 so
// the alternate-mode slots fit in the frame.
module tsm_slot_decode import tsm_pkg::*; #(
    parameter int POS_W = 8
) (
    input  logic [POS_W-1:0]                 cnt,
    input  logic [NUM_CH-1:0]                en,
    input  logic                             alt,
    input  logic [2:0]                       slot,
    input  logic [NUM_CH-1:0][POS_W-1:0]     pos_cfg,
    output logic [NUM_CH-1:0]                active,
    output logic [NUM_CH-1:0][IDX_W-1:0]     idx,
    output logic [NUM_CH-1:0]                last,
    output logic                             tsm
);
    logic [NUM_CH-1:0] hit;

    assign tsm = |en;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [POS_W-1:0] p;
        logic [POS_W-1:0] off;

        // Pick the start position and test whether cnt falls in the slot.
        always_comb begin
            if (alt)       p = POS_W'(int'(slot) * GCI_SLOT_BITS + gci_ofs(c));
            else if (!tsm) p = POS_W'(def_ofs(c));
            else           p = pos_cfg[c];
            off    = cnt - p;
            hit[c] = (!tsm || en[c]) && (cnt >= p) &&
                     ({1'b0, cnt} < ({1'b0, p} + (POS_W+1)'(ch_len(c))));
        end

        assign idx[c]  = off[IDX_W-1:0];
        assign last[c] = (off == POS_W'(ch_len(c) - 1));

        // Priority: a channel wins only if no lower index hits.
        if (c == 0) begin : g_first
            assign active[c] = hit[c];
        end else begin : g_rest
            assign active[c] = hit[c] && !(|hit[c-1:0]);
        end
    end
endmodule

// File: rtl/tsm_rx_capture.sv
// Receive shift register for one channel. Shifts ser_in on each bit
// tick the channel owns and publishes the value after its last bit.
// Assumes LEN >= 2.
module tsm_rx_capture #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_en,
    input  logic           own,
    input  logic           last,
    input  logic           ser_in,
    output logic [LEN-1:0] data,
    output logic           valid
);
    logic [LEN-1:0] sh;

    // Collect owned bits, emit a one-clock valid at the channel end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (bit_en && own) begin
                sh <= {sh[LEN-2:0], ser_in};
                if (last) begin
                    data  <= {sh[LEN-2:0], ser_in};
                    valid <= 1'b1;
                end
            end
        end
    end

    // R12
    // valid_single_pulse_chk
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/tsm_dcl_gen.sv
// Alternate-mode data clock generator. Divides clk (the reference) by
// 6, 8 or 24; the rate code is latched only on a frame tick. Held low
// while the alternate mode is off.
module tsm_dcl_gen #(
    parameter int DIV_FAST = 6,
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    input  logic       alt_mode,
    input  logic [1:0] clk_sel,
    output logic       dcl_out
);
    localparam int CNT_W = $clog2(DIV_SLOW);

    logic [1:0]       sel_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // Latch the rate code at frame boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n)          sel_q <= 2'b00;
        else if (frame_tick) sel_q <= clk_sel;
    end

    // Half-period length for the latched code.
    always_comb begin
        case (sel_q)
            2'b10:   half_m1 = CNT_W'(DIV_MID / 2 - 1);
            2'b11:   half_m1 = CNT_W'(DIV_SLOW / 2 - 1);
            default: half_m1 = CNT_W'(DIV_FAST / 2 - 1);
        endcase
    end

    // Toggle the output every half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !alt_mode) begin
            cnt     <= '0;
            dcl_out <= 1'b0;
        end else if (cnt >= half_m1) begin
            cnt     <= '0;
            dcl_out <= ~dcl_out;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    // dcl_quiet_chk
    dcl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_mode |=> !dcl_out);
endmodule

// File: rtl/tdm_slot_mapper.sv
// Top of the TDM channel timeslot mapper. Ties the bit counter, the
// slot decoder, three receive registers and the data clock divider,
// and drives the serial output. Assumes configuration changes only
// between frames.
module tdm_slot_mapper import tsm_pkg::*; #(
    parameter int FRAME_BITS = 256,
    parameter int DIV_FAST   = 6,
    parameter int DIV_MID    = 8,
    parameter int DIV_SLOW   = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    input  logic                          fsync,
    input  logic                          ser_in,
    input  logic [2:0]                    cfg_en,
    input  logic [$clog2(FRAME_BITS)-1:0] cfg_pos_b1,
    input  logic [$clog2(FRAME_BITS)-1:0] cfg_pos_b2,
    input  logic [$clog2(FRAME_BITS)-1:0] cfg_pos_d,
    input  logic                          cfg_open_drain,
    input  logic                          cfg_alt_mode,
    input  logic [2:0]                    cfg_alt_slot,
    input  logic [1:0]                    cfg_clk_sel,
    input  logic [7:0]                    tx_b1,
    input  logic [7:0]                    tx_b2,
    input  logic [1:0]                    tx_d,
    output logic                          ser_out,
    output logic                          ser_oe,
    output logic [2:0]                    line_ones,
    output logic [7:0]                    rx_b1,
    output logic [7:0]                    rx_b2,
    output logic [1:0]                    rx_d,
    output logic [2:0]                    rx_valid,
    output logic                          dcl_out
);
    localparam int POS_W = $clog2(FRAME_BITS);

    logic [POS_W-1:0]                cnt;
    logic [NUM_CH-1:0][POS_W-1:0]    pos_cfg;
    logic [NUM_CH-1:0]               active;
    logic [NUM_CH-1:0][IDX_W-1:0]    idx;
    logic [NUM_CH-1:0]               last;
    logic                            tsm;
    logic                            bit_val;
    logic                            drive;

    assign pos_cfg = {cfg_pos_d, cfg_pos_b2, cfg_pos_b1};

    tsm_bit_counter #(.POS_W(POS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .cnt(cnt)
    );

    tsm_slot_decode #(.POS_W(POS_W)) u_dec (
        .cnt(cnt), .en(cfg_en), .alt(cfg_alt_mode), .slot(cfg_alt_slot),
        .pos_cfg(pos_cfg), .active(active), .idx(idx), .last(last), .tsm(tsm)
    );

    // Select the owning channel's data bit, MSB first.
    always_comb begin
        if (active[0])      bit_val = tx_b1[IDX_W'(B_BITS - 1) - idx[0]];
        else if (active[1]) bit_val = tx_b2[IDX_W'(B_BITS - 1) - idx[1]];
        else                bit_val = (idx[2] == '0) ? tx_d[1] : tx_d[0];
    end

    // Output drive: push-pull on owned bits, or pull-low-only.
    always_comb begin
        drive   = |active;
        ser_oe  = cfg_open_drain ? (drive && !bit_val) : drive;
        ser_out = ser_oe ? bit_val : 1'b1;
    end

    // Idle-ones request for channels left out of timeslot mode.
    assign line_ones = tsm ? ~cfg_en : 3'b000;

    tsm_rx_capture #(.LEN(B_BITS)) u_rx_b1 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .own(active[0]),
        .last(last[0]), .ser_in(ser_in), .data(rx_b1), .valid(rx_valid[0])
    );
    tsm_rx_capture #(.LEN(B_BITS)) u_rx_b2 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .own(active[1]),
        .last(last[1]), .ser_in(ser_in), .data(rx_b2), .valid(rx_valid[1])
    );
    tsm_rx_capture #(.LEN(D_BITS)) u_rx_d (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .own(active[2]),
        .last(last[2]), .ser_in(ser_in), .data(rx_d), .valid(rx_valid[2])
    );

    tsm_dcl_gen #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_dcl (
        .clk(clk), .rst_n(rst_n), .frame_tick(bit_en && fsync),
        .alt_mode(cfg_alt_mode), .clk_sel(cfg_clk_sel), .dcl_out(dcl_out)
    );

    // R4
    // idle_not_driven_chk
    idle_not_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ones & active) == 3'b000);

    // R8
    // open_drain_low_chk
    open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open_drain && ser_oe) |-> !ser_out);
endmodule

// File: tb/tb_tdm_slot_mapper.sv
`timescale 1ns/1ps
module tb_tdm_slot_mapper;
    localparam int FB = 256;

    logic       clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, fsync = 1'b0, ser_in = 1'b0;
    logic [2:0] cfg_en = '0;
    logic [7:0] cfg_pos_b1 = 8'd40, cfg_pos_b2 = 8'd100, cfg_pos_d = 8'd200;
    logic       cfg_open_drain = 1'b0, cfg_alt_mode = 1'b0;
    logic [2:0] cfg_alt_slot = '0;
    logic [1:0] cfg_clk_sel = '0;
    logic [7:0] tx_b1 = 8'hA5, tx_b2 = 8'h3C;
    logic [1:0] tx_d = 2'b10;
    logic       ser_out, ser_oe, dcl_out;
    logic [2:0] line_ones, rx_valid;
    logic [7:0] rx_b1, rx_b2;
    logic [1:0] rx_d;

    tdm_slot_mapper dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0, mcnt = FB - 1;
    int ser_err, rx_err;
    string ser_msg, rx_msg;
    logic [7:0] esh [3] = '{8'h00, 8'h00, 8'h00};

    // {en[2:0], open_drain, alt, slot[2:0]}
    localparam logic [7:0] VEC [18] = '{
        8'b000_0_0_000, 8'b000_1_0_000, 8'b001_0_0_000, 8'b001_1_0_000,
        8'b010_0_0_000, 8'b010_1_0_000, 8'b011_0_0_000, 8'b011_1_0_000,
        8'b100_0_0_000, 8'b100_1_0_000, 8'b101_0_0_000, 8'b101_1_0_000,
        8'b110_0_0_000, 8'b110_1_0_000, 8'b111_0_0_000, 8'b111_1_0_000,
        8'b000_0_1_011, 8'b101_1_1_110};

    task automatic check(input string tag, input bit ok, input string detail);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    function automatic int clen(input int c);
        return (c == 2) ? 2 : 8;
    endfunction

    function automatic int epos(input int c);
        if (cfg_alt_mode) return int'(cfg_alt_slot) * 32 + ((c == 0) ? 0 : (c == 1) ? 8 : 24);
        if (cfg_en == 3'b000) return c * 8;
        return (c == 0) ? int'(cfg_pos_b1) : (c == 1) ? int'(cfg_pos_b2) : int'(cfg_pos_d);
    endfunction

    function automatic int owner(input int cnt, output int k);
        k = 0;
        for (int c = 0; c < 3; c++) begin
            if ((cfg_en == 3'b000 || cfg_en[c]) && cnt >= epos(c) && cnt < epos(c) + clen(c)) begin
                k = cnt - epos(c);
                return c;
            end
        end
        return -1;
    endfunction

    function automatic bit pin(input int cnt);
        return cnt[0] ^ cnt[2] ^ cnt[5] ^ cnt[6];
    endfunction

    function automatic bit txbit(input int c, input int k);
        if (c == 0) return tx_b1[7-k];
        if (c == 1) return tx_b2[7-k];
        return tx_d[1-k];
    endfunction

    // One serial bit: drive the tick, then compare against the model.
    task automatic step(input bit fs);
        int k, o, k2, o2;
        logic [2:0] ev;
        bit eoe, eout;
        o = owner(mcnt, k);
        ev = 3'b000;
        @(negedge clk);
        bit_en = 1'b1; fsync = fs; ser_in = pin(mcnt);
        if (o >= 0) begin
            esh[o] = {esh[o][6:0], pin(mcnt)};
            if (k == clen(o) - 1) ev[o] = 1'b1;
        end
        mcnt = fs ? 0 : (mcnt + 1) % FB;
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b0;
        o2 = owner(mcnt, k2);
        eoe = (o2 >= 0) && (!cfg_open_drain || !txbit(o2, k2));
        eout = eoe ? txbit(o2, k2) : 1'b1;
        if (ser_oe !== eoe || ser_out !== eout) begin
            if (ser_err == 0)
                ser_msg = $sformatf("bit %0d oe/out got %b%b exp %b%b", mcnt, ser_oe, ser_out, eoe, eout);
            ser_err++;
        end
        if (rx_valid !== ev ||
            (ev[0] && rx_b1 !== esh[0]) || (ev[1] && rx_b2 !== esh[1]) || (ev[2] && rx_d !== esh[2][1:0])) begin
            if (rx_err == 0)
                rx_msg = $sformatf("after bit %0d valid got %b exp %b rx %h/%h/%h exp %h/%h/%h",
                                   mcnt, rx_valid, ev, rx_b1, rx_b2, rx_d, esh[0], esh[1], esh[2][1:0]);
            rx_err++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input string tag);
        logic [2:0] eline;
        ser_err = 0; rx_err = 0; ser_msg = ""; rx_msg = "";
        step(1'b1);
        for (int b = 1; b < FB; b++) step(1'b0);
        check(tag, ser_err == 0, ser_msg);
        check("R12", rx_err == 0, rx_msg);
        eline = (cfg_en != 3'b000) ? ~cfg_en : 3'b000;
        check("R4", line_ones === eline, $sformatf("line_ones got %b exp %b", line_ones, eline));
    endtask

    task automatic measure(input string tag, input int exp_p);
        int n, lim;
        lim = 0;
        while (dcl_out !== 1'b0 && lim < 100) begin @(negedge clk); lim++; end
        while (dcl_out !== 1'b1 && lim < 100) begin @(negedge clk); lim++; end
        n = 0;
        @(negedge clk); n++;
        while (dcl_out !== 1'b0 && n < 100) begin @(negedge clk); n++; end
        while (dcl_out !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        check(tag, n == exp_p, $sformatf("dcl period got %0d exp %0d", n, exp_p));
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", ser_oe === 1'b0 && rx_valid === 3'b000 && dcl_out === 1'b0 && line_ones === 3'b000,
              $sformatf("reset oe/valid/dcl/line got %b/%b/%b/%b exp 0/000/0/000",
                        ser_oe, rx_valid, dcl_out, line_ones));

        // Table walk: R2 default, R3 programmed, R9 alternate; R5/R7/R8 data and drive.
        for (int v = 0; v < 18; v++) begin
            @(negedge clk);
            {cfg_en, cfg_open_drain, cfg_alt_mode, cfg_alt_slot} = VEC[v];
            tx_b1 = 8'hA5 + 8'(v * 17);
            tx_b2 = 8'h3C ^ 8'(v * 5);
            tx_d  = 2'(v + 2);
            run_frame($sformatf("%s R5 %s",
                      cfg_alt_mode ? "R9" : (cfg_en == 3'b000 ? "R2" : "R3"),
                      cfg_open_drain ? "R8" : "R7"));
        end

        // R6 overlapping slots
        @(negedge clk);
        cfg_alt_mode = 1'b0; cfg_open_drain = 1'b0; cfg_en = 3'b111;
        cfg_pos_b1 = 8'd40; cfg_pos_b2 = 8'd44; cfg_pos_d = 8'd46;
        run_frame("R6");

        // R1 mid-frame sync restarts at bit 0 (default layout, B1 first)
        @(negedge clk);
        cfg_en = 3'b000; tx_b1 = 8'h80;
        ser_err = 0; rx_err = 0;
        for (int b = 0; b < 5; b++) step(1'b0);
        step(1'b1);
        check("R1", ser_oe === 1'b1 && ser_out === 1'b1,
              $sformatf("bit0 oe/out got %b%b exp 11", ser_oe, ser_out));

        // R10 / R11 data clock
        @(negedge clk);
        cfg_alt_mode = 1'b1; cfg_clk_sel = 2'b11;
        step(1'b1);
        measure("R10", 24);
        cfg_clk_sel = 2'b10;
        step(1'b0);
        measure("R11", 24);
        step(1'b1);
        measure("R10 R11", 8);
        cfg_clk_sel = 2'b00;
        step(1'b1);
        measure("R10", 6);
        cfg_clk_sel = 2'b01;
        step(1'b1);
        measure("R10", 6);
        @(negedge clk);
        cfg_alt_mode = 1'b0;
        begin
            int hi;
            hi = 0;
            repeat (2) @(negedge clk);
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (dcl_out !== 1'b0) hi++;
            end
            check("R10", hi == 0, $sformatf("dcl high cycles got %0d exp 0", hi));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule